// File: doc/BRIEF.md
# High-Speed Compare Toggle Channel

This block is one compare channel attached to a free-running timebase counter. Software loads a compare value one byte at a time, as a low byte and a high byte. When the timebase reaches that value, the channel can invert its output pin. It can also set a sticky event flag, and that flag drives an interrupt request when the interrupt is enabled.

Writing the low byte disarms the comparator, and writing the high byte arms it again. A 16-bit value loaded byte by byte therefore never matches against a half-updated register. A match is taken once for each new timebase value, however many clock cycles the counter holds that value. A byte write in the same cycle as a match suppresses the match.

The byte width is a parameter, and the compare width is twice the byte width. Clock prescaling, pin routing and the other operating modes belong to neighbouring logic.

Top module: `hscmp_channel`

## Requirements
- R1: After reset the pin is low, the flag and the interrupt request are low, the compare value is zero and the comparator is armed. The first timebase value of zero therefore matches.
- R2: A match needs every bit of the timebase count to equal every bit of the compare value. The pin, the flag and the interrupt request change on the clock edge that samples the match.
- R3: Writing only the low byte loads it and disarms the comparator. No match occurs until the high byte is written.
- R4: Writing the high byte loads it and arms the comparator.
- R5: The pin inverts on a match only when the toggle enable is 1. Otherwise it holds its level.
- R6: A match sets the flag only when the flag enable is 1. The flag stays set until the clear strobe is applied. When a setting match and the clear strobe fall in the same cycle, the flag stays set.
- R7: The interrupt request is high exactly while the flag is set and the interrupt enable is 1.
- R8: With the compare enable at 0, no match occurs. The pin and the flag are left unchanged.
- R9: A timebase value held for several cycles produces at most one match. A value counts as new when it differs from the value seen on the previous cycle, and the first value after reset is always new.
- R10: A byte write in the same cycle as a match suppresses that match.
- R11: When both byte strobes are asserted in the same cycle, both bytes are loaded and the comparator ends up armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_count_i | input | 2*DATA_W | Timebase counter value |
| wr_lo_i | input | 1 | Load the low byte of the compare value (disarms) |
| wr_hi_i | input | 1 | Load the high byte of the compare value (arms) |
| wr_data_i | input | DATA_W | Byte to load |
| cmp_en_i | input | 1 | Compare enable |
| tog_en_i | input | 1 | Toggle-on-match enable |
| flag_en_i | input | 1 | Flag-on-match enable |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear strobe for the flag |
| pin_o | output | 1 | Channel output level |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck or wrong arm state shows up as a missing or extra pin inversion. That error appears one cycle after the timebase first presents the compare value. A fault in the compare register or the comparator is caught by an exhaustive sweep: every compare value meets every count value, so any miscompare surfaces within one full timebase period. A fault in new-value detection or in flag retention shows up on the second cycle of a held count, or on the cycle after a clear strobe.

// File: rtl/hscmp_pkg.sv
package hscmp_pkg;
  typedef struct packed {
    logic cmp_en;
    logic tog_en;
    logic flag_en;
    logic irq_en;
  } hscmp_mode_t;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/hscmp_rst_sync.sv
module hscmp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/hscmp_regs.sv
module hscmp_regs #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = hscmp_pkg::LANES * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cmp_val_o,
  output logic              armed_o
);
  logic [hscmp_pkg::LANES-1:0] lane_we;
  assign lane_we = {wr_hi_i, wr_lo_i};

  for (genvar g = 0; g < hscmp_pkg::LANES; g++) begin : g_lane
    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (lane_we[g]) byte_d = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else         byte_q <= byte_d;
    end

    assign cmp_val_o[g*DATA_W +: DATA_W] = byte_q;
  end

  logic arm_q;
  logic arm_d;

  // High byte wins over low byte so a combined write leaves the compare armed.
  always_comb begin
    arm_d = arm_q;
    if (wr_lo_i) arm_d = 1'b0;
    if (wr_hi_i) arm_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b1;
    else         arm_q <= arm_d;
  end

  assign armed_o = arm_q;

  a_r3_lo_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> !armed_o);
  a_r4_hi_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> armed_o);
  a_r11_lo_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cmp_val_o[DATA_W-1:0] == $past(wr_data_i));
  a_r4_arm_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> $stable(armed_o));
endmodule

// File: rtl/hscmp_match.sv
module hscmp_match #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             armed_i,
  input  logic             cmp_en_i,
  input  logic             wr_busy_i,
  output logic             match_o
);
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] prev_d;
  logic             seen_q;
  logic             seen_d;
  logic             fresh;
  logic             equal;

  always_comb begin
    prev_d = count_i;
    seen_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      seen_q <= seen_d;
    end
  end

  always_comb begin
    fresh   = !seen_q || (count_i != prev_q);
    equal   = (count_i == cmp_val_i);
    match_o = cmp_en_i && armed_i && fresh && equal && !wr_busy_i;
  end

  a_r9_once_per_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> (!match_o || count_i != $past(count_i)));
  a_r10_write_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_i |-> !match_o);
  a_r2_full_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (count_i == cmp_val_i));
endmodule

// File: rtl/hscmp_out.sv
module hscmp_out (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    match_i,
  input  hscmp_pkg::hscmp_mode_t  mode_i,
  input  logic                    flag_clr_i,
  output logic                    pin_o,
  output logic                    flag_o,
  output logic                    irq_o
);
  logic pin_q, pin_d;
  logic flag_q, flag_d;

  always_comb begin
    pin_d  = pin_q;
    flag_d = flag_q;
    if (match_i && mode_i.tog_en) pin_d = !pin_q;
    if (flag_clr_i)               flag_d = 1'b0;
    if (match_i && mode_i.flag_en) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      flag_q <= flag_d;
    end
  end

  assign pin_o  = pin_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q && mode_i.irq_en;

  a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i.tog_en) |=> pin_o != $past(pin_o));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match_i && mode_i.tog_en) |=> $stable(pin_o));
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode_i.flag_en) |=> flag_o);
  a_r7_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

// File: rtl/hscmp_channel.sv
module hscmp_channel #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = hscmp_pkg::LANES * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  tb_count_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cmp_en_i,
  input  logic              tog_en_i,
  input  logic              flag_en_i,
  input  logic              irq_en_i,
  input  logic              flag_clr_i,
  output logic              pin_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic                   rst_n;
  logic [CNT_W-1:0]       cmp_val;
  logic                   armed;
  logic                   match;
  hscmp_pkg::hscmp_mode_t mode;

  assign mode = '{cmp_en: cmp_en_i, tog_en: tog_en_i,
                  flag_en: flag_en_i, irq_en: irq_en_i};

  hscmp_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  hscmp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .cmp_val_o (cmp_val),
    .armed_o   (armed)
  );

  hscmp_match #(.CNT_W(CNT_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .count_i   (tb_count_i),
    .cmp_val_i (cmp_val),
    .armed_i   (armed),
    .cmp_en_i  (mode.cmp_en),
    .wr_busy_i (wr_lo_i || wr_hi_i),
    .match_o   (match)
  );

  hscmp_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .match_i    (match),
    .mode_i     (mode),
    .flag_clr_i (flag_clr_i),
    .pin_o      (pin_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
  );

  a_r8_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cmp_en_i |=> ($stable(pin_o) && (flag_o || !$past(flag_o) || $past(flag_clr_i))));
  a_r3_disarmed_no_match: assert property (@(posedge clk_i) disable iff (!rst_n)
    !armed |-> !match);
endmodule

// File: tb/hscmp_channel_bench.sv
module hscmp_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int CW = 2 * DW;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [CW-1:0] tb_count;
  logic          wr_lo, wr_hi, cmp_en, tog_en, flag_en, irq_en, flag_clr;
  logic [DW-1:0] wr_data;
  logic          pin, flag, irq;

  int n_vec = 0;
  int n_bad = 0;

  // reference state
  logic [CW-1:0] m_cmp;
  logic          m_arm, m_seen, m_pin, m_flag;
  logic [CW-1:0] m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  hscmp_channel #(.DATA_W(DW)) u_hscmp_channel (
    .clk_i(clk), .rst_ni(rst_ni), .tb_count_i(tb_count),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .cmp_en_i(cmp_en), .tog_en_i(tog_en), .flag_en_i(flag_en),
    .irq_en_i(irq_en), .flag_clr_i(flag_clr),
    .pin_o(pin), .flag_o(flag), .irq_o(irq)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, predict from the requirements, compare after the edge.
  task automatic apply(string tag, logic [CW-1:0] cnt, logic wl, logic wh,
                       logic [DW-1:0] d, logic clr);
    logic fresh, hit;
    tb_count = cnt; wr_lo = wl; wr_hi = wh; wr_data = d; flag_clr = clr;
    fresh = !m_seen || (cnt != m_prev);
    hit   = cmp_en && m_arm && fresh && (cnt == m_cmp) && !(wl || wh);
    @(posedge clk);
    @(negedge clk);
    if (hit && tog_en) m_pin = !m_pin;
    if (clr) m_flag = 1'b0;
    if (hit && flag_en) m_flag = 1'b1;
    if (wl) m_cmp[DW-1:0] = d;
    if (wh) m_cmp[CW-1:DW] = d;
    if (wl) m_arm = 1'b0;
    if (wh) m_arm = 1'b1;
    m_prev = cnt; m_seen = 1'b1;
    check(tag, "pin", pin, m_pin);
    check(tag, "flag", flag, m_flag);
    check(tag, "irq", irq, m_flag && irq_en);
    wr_lo = 0; wr_hi = 0; flag_clr = 0;
  endtask

  task automatic load(string tag, logic [CW-1:0] v);
    apply(tag, tb_count, 1'b1, 1'b0, v[DW-1:0], 1'b0);
    apply(tag, tb_count, 1'b0, 1'b1, v[CW-1:DW], 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 0; tb_count = '0; wr_lo = 0; wr_hi = 0; wr_data = '0;
    cmp_en = 1; tog_en = 1; flag_en = 1; irq_en = 1; flag_clr = 0;
    m_cmp = '0; m_arm = 1; m_seen = 0; m_pin = 0; m_flag = 0; m_prev = '0;
    repeat (3) @(negedge clk);
    check("R1", "pin", pin, 1'b0);
    check("R1", "flag", flag, 1'b0);
    check("R1", "irq", irq, 1'b0);
    rst_ni = 1;
    repeat (2) @(negedge clk);   // synchronizer release, model stays at reset
    // R1: zero compare, armed: first count of zero matches
    apply("R1", 8'h00, 0, 0, '0, 0);
    check("R1", "pin_after_first_zero", pin, 1'b1);

    // R2: exhaustive sweep of compare against count
    for (int c = 0; c < (1 << CW); c++) begin
      tog_en  = (c % 7) != 3;
      flag_en = c[0];
      irq_en  = c[1];
      load("R2", c[CW-1:0]);
      for (int k = 0; k < (1 << CW); k++)
        apply("R2", k[CW-1:0], 0, 0, '0, (k == 128));
    end

    tog_en = 1; flag_en = 1; irq_en = 1;
    apply("R6", 8'h00, 0, 0, '0, 1);
    // R9: held count matches once
    load("R9", 8'h55);
    apply("R9", 8'h54, 0, 0, '0, 0);
    for (int i = 0; i < 4; i++) apply("R9", 8'h55, 0, 0, '0, 0);

    // R3: low-only write leaves the compare disarmed
    apply("R3", 8'h10, 1, 0, 4'h6, 0);
    apply("R3", 8'h56, 0, 0, '0, 0);
    apply("R3", 8'h10, 0, 0, '0, 0);
    apply("R3", 8'h56, 0, 0, '0, 0);
    // R4: high write re-arms
    apply("R4", 8'h10, 0, 1, 4'h5, 0);
    apply("R4", 8'h56, 0, 0, '0, 0);

    // R10: write coincident with match blocks it
    load("R10", 8'h20);
    apply("R10", 8'h1F, 0, 0, '0, 0);
    apply("R10", 8'h20, 0, 1, 4'h2, 0);
    apply("R10", 8'h20, 0, 0, '0, 0);

    // R11: both strobes together arm
    apply("R11", 8'h00, 1, 0, 4'h1, 0);
    apply("R11", 8'h00, 1, 1, 4'h3, 0);
    apply("R11", 8'h33, 0, 0, '0, 0);

    // R8: compare disabled
    cmp_en = 0;
    apply("R8", 8'h32, 0, 0, '0, 1);
    apply("R8", 8'h33, 0, 0, '0, 0);
    cmp_en = 1;

    // R5: toggle off, flag still set
    tog_en = 0;
    apply("R5", 8'h32, 0, 0, '0, 0);
    apply("R5", 8'h33, 0, 0, '0, 0);
    tog_en = 1;

    // R6: set beats clear, clear alone clears
    apply("R6", 8'h32, 0, 0, '0, 0);
    apply("R6", 8'h33, 0, 0, '0, 1);
    check("R6", "flag_set_wins", flag, 1'b1);
    apply("R6", 8'h34, 0, 0, '0, 0);
    apply("R6", 8'h35, 0, 0, '0, 1);
    check("R6", "flag_cleared", flag, 1'b0);

    // R7: irq follows enable
    apply("R7", 8'h33, 0, 0, '0, 0);
    irq_en = 0;
    #1 check("R7", "irq_masked", irq, 1'b0);
    irq_en = 1;
    #1 check("R7", "irq_unmasked", irq, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule